// File: doc/BRIEF.md
# I2C Variable-Length Register Write Slave

This block is the write side of an I2C slave that feeds a register map in which each subaddress holds its own number of 32-bit words. It watches already-synchronized SCL and SDA, finds start and stop conditions, and compares the first byte of a transfer against the 7-bit device address 0x36. When the address matches and the transfer is a write, it accepts a subaddress byte and then gathers data bytes into a staging buffer. A target register is updated only once every byte of its word set has arrived.

Each complete set is handed to storage as a one-cycle commit strobe. The strobe carries the subaddress, the word count and a 160-bit data bus. The target subaddress then advances by one, so a long burst fills a run of consecutive registers. If a stop or a repeated start cuts a set short, the bytes staged for that set are thrown away. Sets that were completed earlier in the same burst stay committed. Reads, addresses that do not match and all other traffic are never acknowledged.

Top module: `i2c_varlen_wr_slave`

## Requirements
- R1: The first byte after a start is taken as address bits [7:1] (MSB first) plus the R/W flag in bit 0. The value 0x36 with R/W = 0 is acknowledged by holding SDA low for the ninth clock.
- R2: In an accepted write, the subaddress byte and every data byte after it are acknowledged.
- R3: A byte in the address slot whose bits [7:1] are not 0x36, or whose bit 0 is 1, is not acknowledged. Nothing in the rest of that transfer is acknowledged or committed until the next start.
- R4: Subaddresses 0x10 to 0x1F take five words (20 bytes). Every other subaddress takes one word (4 bytes). The word count is reported on `commit_nwords`.
- R5: Bytes are packed big-endian. Word k sits in `commit_data[32k+31:32k]`, and the first byte of each word lands in bits 31:24 of that word. Words past the count are zero.
- R6: A commit is a single-cycle pulse on `commit_valid` with the address, count and data valid in the same cycle. No commit is issued while reset is active.
- R7: A stop that arrives before a set is complete causes no commit for that subaddress.
- R8: A repeated start that arrives before a set is complete discards the partial set. The new transfer then proceeds normally.
- R9: In a burst, each completed set moves the target to the next subaddress. Each target uses its own length, including across the 0x0F/0x10 and 0x1F/0x20 boundaries. Only a trailing partial set is dropped.
- R10: The block starts driving SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA bus level |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_addr | output | 8 | Subaddress being updated |
| commit_nwords | output | 3 | Number of valid words in the commit |
| commit_data | output | 160 | Packed word set, word 0 in the low bits |

## Verification
The bench sends single mixer writes, full filter-section writes and a single-byte write, which tell a proper length lookup apart from a fixed four-byte rule. A burst that starts at 0x0E and crosses into the five-word range, and a second burst that leaves it at 0x1F, separate per-target lengths from a length latched once per transfer. Stops and repeated starts in the middle of a set show whether partial data leaks into storage. A foreign address and a read request check that nothing is acknowledged and nothing is written until the next start.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int          BYTE_BITS   = 8;
    localparam int          WORD_W      = 32;
    localparam int          BPW         = WORD_W / BYTE_BITS;
    localparam int          MAX_WORDS   = 5;
    localparam int          MAX_BYTES   = MAX_WORDS * BPW;
    localparam int          DATA_W      = MAX_WORDS * WORD_W;
    localparam int          SUB_W       = 8;
    localparam int          NW_W        = $clog2(MAX_WORDS + 1);
    localparam int          IDX_W       = $clog2(MAX_BYTES + 1);
    localparam int          BITCNT_W    = $clog2(BYTE_BITS + 1);
    localparam logic [6:0]  SLAVE_ADDR  = 7'h36;
    localparam logic [7:0]  LONG_FIRST  = 8'h10;
    localparam logic [7:0]  LONG_LAST   = 8'h1F;
    localparam int          LONG_WORDS  = 5;
    localparam int          SHORT_WORDS = 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_DATA,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_ev_t;

    typedef struct packed {
        logic              valid;
        logic [SUB_W-1:0]  addr;
        logic [NW_W-1:0]   nwords;
        logic [DATA_W-1:0] data;
    } commit_t;

    // Word-count lookup for the register map.
    function automatic logic [NW_W-1:0] words_for(input logic [SUB_W-1:0] sub);
        if (sub >= LONG_FIRST && sub <= LONG_LAST)
            return NW_W'(LONG_WORDS);
        return NW_W'(SHORT_WORDS);
    endfunction

endpackage

// File: rtl/i2cw_bus_cond.sv
module i2cw_bus_cond
    import i2cw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // SDA edges while SCL stays high mark bus conditions.
    always_comb begin
        ev.scl_rise = scl_i & ~scl_q;
        ev.scl_fall = ~scl_i & scl_q;
        ev.start    = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/i2cw_byte_rx.sv
module i2cw_byte_rx
    import i2cw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bus_ev_t              ev,
    input  logic                 sda_i,
    input  logic                 ack_en,
    output logic                 byte_done,
    output logic [BYTE_BITS-1:0] byte_val,
    output logic                 sda_oe
);

    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_BITS - 1);
    localparam logic [BITCNT_W-1:0] FULL     = BITCNT_W'(BYTE_BITS);

    logic [BYTE_BITS-1:0] shreg;
    logic [BITCNT_W-1:0]  bitcnt;
    logic                 in_ack;
    logic                 oe_q;
    logic                 done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            bitcnt <= '0;
            in_ack <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ev.start || ev.stop) begin
                bitcnt <= '0;
                in_ack <= 1'b0;
                oe_q   <= 1'b0;
            end else begin
                if (ev.scl_rise && bitcnt < FULL) begin
                    shreg  <= {shreg[BYTE_BITS-2:0], sda_i};
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == LAST_BIT)
                        done_q <= 1'b1;
                end
                if (ev.scl_fall && bitcnt == FULL) begin
                    if (!in_ack) begin
                        // Ninth clock begins: drive ACK if requested.
                        in_ack <= 1'b1;
                        oe_q   <= ack_en;
                    end else begin
                        // Ninth clock over: release and start next byte.
                        in_ack <= 1'b0;
                        oe_q   <= 1'b0;
                        bitcnt <= '0;
                    end
                end
            end
        end
    end

    assign byte_done = done_q;
    assign byte_val  = shreg;
    assign sda_oe    = oe_q;

endmodule

// File: rtl/i2cw_stage.sv
module i2cw_stage
    import i2cw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [SUB_W-1:0]     sub_in,
    input  logic                 push,
    input  logic [BYTE_BITS-1:0] byte_in,
    input  logic                 abort,
    output commit_t              cmt
);

    logic [BYTE_BITS-1:0] bytes_q [MAX_BYTES];
    logic [SUB_W-1:0]     cur_sub;
    logic [IDX_W-1:0]     idx;
    logic                 pend;
    logic [NW_W-1:0]      cur_words;
    logic [IDX_W-1:0]     need;
    logic [DATA_W-1:0]    packed_data;

    assign cur_words = words_for(cur_sub);
    assign need      = IDX_W'(cur_words) * IDX_W'(BPW);

    // Big-endian packing; bytes past the set length read as zero.
    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_pack
        localparam int POS = WORD_W * (i / BPW) + (WORD_W - BYTE_BITS) - BYTE_BITS * (i % BPW);
        assign packed_data[POS +: BYTE_BITS] = (IDX_W'(i) < need) ? bytes_q[i] : '0;
    end

    always_ff @(posedge clk) begin
        if (push && !load && !abort)
            bytes_q[idx] <= byte_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_sub <= '0;
            idx     <= '0;
            pend    <= 1'b0;
            cmt     <= '0;
        end else begin
            cmt.valid <= 1'b0;
            pend      <= 1'b0;
            if (pend) begin
                cmt.valid  <= 1'b1;
                cmt.addr   <= cur_sub;
                cmt.nwords <= cur_words;
                cmt.data   <= packed_data;
                cur_sub    <= cur_sub + 1'b1;
            end
            if (load) begin
                cur_sub <= sub_in;
                idx     <= '0;
            end else if (abort) begin
                idx <= '0;
            end else if (push) begin
                if (idx == need - 1'b1) begin
                    idx  <= '0;
                    pend <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2c_varlen_wr_slave.sv
module i2c_varlen_wr_slave
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              commit_valid,
    output logic [SUB_W-1:0]  commit_addr,
    output logic [NW_W-1:0]   commit_nwords,
    output logic [DATA_W-1:0] commit_data
);

    bus_ev_t              ev;
    phase_t               phase;
    logic                 ack_q;
    logic                 byte_done;
    logic [BYTE_BITS-1:0] byte_val;
    logic                 addr_hit;
    commit_t              cmt;

    i2cw_bus_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cw_byte_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .sda_i     (sda_i),
        .ack_en    (ack_q),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .sda_oe    (sda_oe)
    );

    assign addr_hit = (byte_val[BYTE_BITS-1:1] == SLAVE_ADDR) && !byte_val[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            ack_q <= 1'b0;
        end else if (ev.start) begin
            phase <= PH_ADDR;
            ack_q <= 1'b0;
        end else if (ev.stop) begin
            phase <= PH_IDLE;
            ack_q <= 1'b0;
        end else if (byte_done) begin
            unique case (phase)
                PH_ADDR: begin
                    phase <= addr_hit ? PH_SUB : PH_SKIP;
                    ack_q <= addr_hit;
                end
                PH_SUB: begin
                    phase <= PH_DATA;
                    ack_q <= 1'b1;
                end
                PH_DATA: ack_q <= 1'b1;
                default: ack_q <= 1'b0;
            endcase
        end
    end

    i2cw_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .load    (byte_done && phase == PH_SUB),
        .sub_in  (byte_val),
        .push    (byte_done && phase == PH_DATA),
        .byte_in (byte_val),
        .abort   (ev.start || ev.stop),
        .cmt     (cmt)
    );

    assign commit_valid  = cmt.valid;
    assign commit_addr   = cmt.addr;
    assign commit_nwords = cmt.nwords;
    assign commit_data   = cmt.data;

endmodule

// File: rtl/i2cw_checks.sv
module i2cw_checks
    import i2cw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_oe,
    input logic              commit_valid,
    input logic [SUB_W-1:0]  commit_addr,
    input logic [NW_W-1:0]   commit_nwords,
    input logic [DATA_W-1:0] commit_data
);

    logic             scl_d, sda_d, have_prev;
    logic [SUB_W-1:0] last_addr;
    logic             saw_start;

    assign saw_start = scl_i && scl_d && sda_d && !sda_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d     <= 1'b1;
            sda_d     <= 1'b1;
            have_prev <= 1'b0;
            last_addr <= '0;
        end else begin
            scl_d <= scl_i;
            sda_d <= sda_i;
            if (saw_start) begin
                have_prev <= 1'b0;
            end else if (commit_valid) begin
                have_prev <= 1'b1;
                last_addr <= commit_addr;
            end
        end
    end

    assert_ack_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    assert_commit_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        commit_valid |=> !commit_valid);

    assert_len_map_R4: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> (commit_nwords ==
            ((commit_addr >= 8'h10 && commit_addr <= 8'h1F) ? 3'd5 : 3'd1)));

    assert_zero_pad_R5: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && commit_nwords == 3'd1) |-> (commit_data[DATA_W-1:WORD_W] == '0));

    assert_seq_step_R9: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && have_prev) |-> (commit_addr == last_addr + 1'b1));

endmodule

bind i2c_varlen_wr_slave i2cw_checks u_checks (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl_i),
    .sda_i         (sda_i),
    .sda_oe        (sda_oe),
    .commit_valid  (commit_valid),
    .commit_addr   (commit_addr),
    .commit_nwords (commit_nwords),
    .commit_data   (commit_data)
);

// File: tb/i2c_varlen_wr_slave_test.sv
`timescale 1ns/1ps
module i2c_varlen_wr_slave_test;

    localparam int H = 8;

    typedef struct packed {
        logic [7:0]   a;
        logic [2:0]   n;
        logic [159:0] d;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scl = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_i;
    logic         sda_oe;
    logic         commit_valid;
    logic [7:0]   commit_addr;
    logic [2:0]   commit_nwords;
    logic [159:0] commit_data;

    int   checks = 0;
    int   errors = 0;
    logic [7:0] tx [0:63];
    exp_t q[$];
    exp_t mon_e;
    logic prev_v = 1'b0;
    logic prev_oe = 1'b0;

    always #5 clk = ~clk;

    assign sda_i = sda_m & ~sda_oe;

    i2c_varlen_wr_slave uut (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl),
        .sda_i         (sda_i),
        .sda_oe        (sda_oe),
        .commit_valid  (commit_valid),
        .commit_addr   (commit_addr),
        .commit_nwords (commit_nwords),
        .commit_data   (commit_data)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_words(input logic [7:0] s);
        return (s >= 8'h10 && s <= 8'h1F) ? 5 : 1;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 64; i++) tx[i] = 8'(i * 29 + seed);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H);
        scl = 1'b1;   wt(H);
        sda_m = 1'b0; wt(H);
        scl = 1'b0;   wt(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H);
        scl = 1'b1;   wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H);
            scl = 1'b1;   wt(H);
            scl = 1'b0;   wt(2);
        end
        sda_m = 1'b1; wt(H);
        scl = 1'b1;   wt(H / 2);
        acked = !sda_i;
        wt(H / 2);
        scl = 1'b0;   wt(2);
    endtask

    // Driver: builds the expected commits, then plays the transfer.
    task automatic xfer(input logic [6:0] dev, input bit rw, input logic [7:0] sub,
                        input int nb, input bit end_stop);
        bit           a;
        bit           hit;
        logic [7:0]   cur;
        int           idx;
        int           nw;
        logic [159:0] d;
        hit = (dev == 7'h36) && !rw;
        if (hit) begin
            cur = sub; idx = 0; d = '0;
            for (int i = 0; i < nb; i++) begin
                nw = exp_words(cur);
                d[32 * (idx / 4) + 24 - 8 * (idx % 4) +: 8] = tx[i];
                idx++;
                if (idx == nw * 4) begin
                    q.push_back('{a: cur, n: 3'(nw), d: d});
                    cur = cur + 8'd1; idx = 0; d = '0;
                end
            end
        end
        bus_start();
        send_byte({dev, rw}, a);
        chk(a == hit, hit ? "R1 address ack" : "R3 address not acked", 160'(a), 160'(hit));
        if (!rw) begin
            send_byte(sub, a);
            chk(a == hit, hit ? "R2 subaddress ack" : "R3 subaddress ignored", 160'(a), 160'(hit));
            for (int i = 0; i < nb; i++) begin
                send_byte(tx[i], a);
                chk(a == hit, hit ? "R2 data ack" : "R3 data ignored", 160'(a), 160'(hit));
            end
        end
        if (end_stop) bus_stop();
    endtask

    // Monitor: pops expected commits as the design produces them.
    always @(negedge clk) begin
        if (!rst) begin
            if (commit_valid) begin
                if (prev_v) chk(1'b0, "R6 strobe longer than one cycle", 160'(1), 160'(0));
                if (q.size() == 0) begin
                    chk(1'b0, "R7 R8 unexpected commit", 160'(commit_addr), 160'(0));
                end else begin
                    mon_e = q.pop_front();
                    chk(commit_addr == mon_e.a, "R9 commit address", 160'(commit_addr), 160'(mon_e.a));
                    chk(commit_nwords == mon_e.n, "R4 word count", 160'(commit_nwords), 160'(mon_e.n));
                    chk(commit_data == mon_e.d, "R5 packed data", commit_data, mon_e.d);
                end
            end
            if (sda_oe && !prev_oe)
                chk(!scl, "R10 ack drive starts with SCL low", 160'(scl), 160'(0));
        end
        prev_v  <= commit_valid;
        prev_oe <= sda_oe;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wt(3);
        chk(commit_valid == 1'b0, "R6 no commit in reset", 160'(commit_valid), 160'(0));
        rst = 1'b0;
        wt(5);
        chk(sda_oe == 1'b0 && commit_valid == 1'b0, "R6 idle after reset",
            160'({sda_oe, commit_valid}), 160'(0));

        fill(3);  xfer(7'h36, 1'b0, 8'h03, 4, 1'b1);   // R4 mixer word
        fill(9);  xfer(7'h36, 1'b0, 8'h07, 1, 1'b1);   // R7 single byte only
        fill(17); xfer(7'h36, 1'b0, 8'h12, 20, 1'b1);  // R4 R5 filter section
        fill(41); xfer(7'h36, 1'b0, 8'h0E, 31, 1'b1);  // R9 crosses into long range, partial tail
        fill(5);  xfer(7'h37, 1'b0, 8'h05, 4, 1'b1);   // R3 foreign address
        fill(6);  xfer(7'h36, 1'b1, 8'h00, 0, 1'b1);   // R3 read request
        fill(77); xfer(7'h36, 1'b0, 8'h15, 10, 1'b0);  // R8 partial then repeated start
        fill(88); xfer(7'h36, 1'b0, 8'h05, 4, 1'b1);
        fill(51); xfer(7'h36, 1'b0, 8'h80, 8, 1'b1);   // R4 R9 unmapped, two words
        fill(63); xfer(7'h36, 1'b0, 8'h1F, 24, 1'b1);  // R9 leaves long range

        wt(20);
        chk(q.size() == 0, "R7 R8 expected commits left over", 160'(q.size()), 160'(0));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule